// File: doc/BRIEF.md
# I2C Register Port with Time Snapshot

This block is the serial front end of a timekeeping register file. It acts as an I2C target on a two-wire bus, sampling the clock and data lines with the system clock, and gives a bus master byte-wide access to a 16-entry register space. A transaction opens with a START and an address byte carrying the read/write flag. In a write, the first data byte sets the register pointer and each later byte is written to the register the pointer selects. In a read, bytes are returned from the pointer onward. The pointer steps after every byte and wraps from the last register back to zero.

The lowest registers hold the running time, which changes while a master is reading it. So that a multi-byte read does not tear, the port keeps a shadow copy of those time bytes. The copy is refreshed on every START (including a repeated START), on every STOP, and at the moment the pointer wraps to zero. Reads of time registers are served from the copy. Registers above the time range are read straight from the live inputs. Writes leave the block as a one-cycle strobe with an address and a data byte, and the register file applies them.

Top module: `i2c_snap_port`

## Requirements
- R1: After reset the port leaves SDA released (`sdaDriveLow` = 0), holds `wrStrobe` low, and sets the register pointer to 0, so a read with no pointer write starts at register 0.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged. The port then drives SDA for no bit and issues no write until the next START.
- R3: In a write transaction the first byte after the address loads the pointer from its low four bits. That byte is acknowledged and produces no write strobe.
- R4: Each later byte of a write transaction is acknowledged and produces exactly one `wrStrobe` pulse, one clock wide, with `wrAddr` equal to the pointer and `wrData` equal to the byte. The pointer then advances by one.
- R5: In a read transaction the port sends the byte at the pointer, most significant bit first, while SCL is low. It advances the pointer after each byte. Registers at index `SNAP_REGS` and above come from `liveRegs` as they stand when the byte is loaded.
- R6: The pointer wraps from 15 to 0 in both reads and writes.
- R7: Registers below `SNAP_REGS` read back the `liveRegs` value held at the last capture event (START, repeated START or STOP). Later changes to `liveRegs` are not seen until the next capture event.
- R8: When the pointer steps from 15 to 0, the shadow copy is refreshed, so register 0 read after the wrap shows the live value at that step.
- R9: A NACK from the master after a read byte ends the transfer. The port releases SDA and drives it for no later clock until the next START.
- R10: Outside a START or STOP condition, the port changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level (wired bus value) |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 releases it |
| liveRegs | input | NUM_REGS*8 | Live register bytes, register n at bits [8n+7:8n] |
| wrStrobe | output | 1 | One-cycle write request |
| wrAddr | output | $clog2(NUM_REGS) | Register index for the write |
| wrData | output | 8 | Byte to write |

## Verification
The bench builds the port with a target address of 35h instead of the default, which shows that both matching and rejection follow the parameter. It keeps the default 16 registers with a 7-byte time range, so short bursts reach the 15-to-0 wrap in both directions. The same build also covers reads that cross from shadowed time bytes into live registers. Live inputs are changed in the middle of transactions, between the pointer write and the repeated START and again between bytes. The returned values then separate a capture on START from a capture on wrap and from a direct live read.

// File: rtl/i2c_snap_pkg.sv
`timescale 1ns/1ps
package i2c_snap_pkg;
  localparam int BYTE_BITS = 8;

  // control-to-datapath strobes, all one cycle wide
  typedef struct packed {
    logic capture;   // refresh shadow (START/STOP)
    logic ptrLoad;   // load pointer from received byte
    logic wrEn;      // write received byte, then step pointer
    logic txLoad;    // byte at pointer taken for transmit, then step pointer
  } portStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } busStateT;

  typedef enum logic [1:0] {
    RK_ADDR,
    RK_PTR,
    RK_DATA
  } rxKindT;
endpackage

// File: rtl/i2c_snap_sync.sv
`timescale 1ns/1ps
module i2c_snap_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  // index 0 is the first flop, SYNC_STAGES-1 the settled level,
  // SYNC_STAGES the level one cycle earlier
  logic [SYNC_STAGES:0] sclPipe;
  logic [SYNC_STAGES:0] sdaPipe;
  logic sclOld, sdaOld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclLvl = sclPipe[SYNC_STAGES-1];
  assign sdaLvl = sdaPipe[SYNC_STAGES-1];
  assign sclOld = sclPipe[SYNC_STAGES];
  assign sdaOld = sdaPipe[SYNC_STAGES];

  assign sclRise  = sclLvl & ~sclOld;
  assign sclFall  = ~sclLvl & sclOld;
  assign startDet = sclLvl & sclOld & sdaOld & ~sdaLvl;
  assign stopDet  = sclLvl & sclOld & ~sdaOld & sdaLvl;

  // R10
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !stopDet);
endmodule

// File: rtl/i2c_snap_ctrl.sv
`timescale 1ns/1ps
module i2c_snap_ctrl
  import i2c_snap_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLvl,
  input  logic       sdaLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rdByte,
  output portStrobeT strb,
  output logic [7:0] rxByte,
  output logic       sdaDriveLow
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

  busStateT         state;
  rxKindT           rxKind;
  logic             isRead;
  logic             masterAck;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0]       shiftReg;
  logic [7:0]       txShift;
  logic             driveLow;
  logic             busEvent;
  logic             addrHit;

  assign busEvent = startDet | stopDet;
  assign addrHit  = (shiftReg[7:1] == DEV_ADDR);
  assign rxByte   = shiftReg;
  assign sdaDriveLow = driveLow;

  always_comb begin
    strb = '0;
    strb.capture = busEvent;
    if (!busEvent && sclFall) begin
      if (state == ST_RX && bitCnt == CNT_FULL) begin
        strb.ptrLoad = (rxKind == RK_PTR);
        strb.wrEn    = (rxKind == RK_DATA);
      end
      if (state == ST_RXACK && isRead) strb.txLoad = 1'b1;
      if (state == ST_TXACK && masterAck) strb.txLoad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rxKind    <= RK_ADDR;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      bitCnt    <= '0;
      shiftReg  <= '0;
      txShift   <= '0;
      driveLow  <= 1'b0;
    end else if (startDet) begin
      state    <= ST_RX;
      rxKind   <= RK_ADDR;
      isRead   <= 1'b0;
      bitCnt   <= '0;
      driveLow <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      driveLow <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && bitCnt != CNT_FULL) begin
            shiftReg <= {shiftReg[6:0], sdaLvl};
            bitCnt   <= bitCnt + 1'b1;
          end else if (sclFall && bitCnt == CNT_FULL) begin
            if (rxKind == RK_ADDR && !addrHit) begin
              state <= ST_IDLE;
            end else begin
              state    <= ST_RXACK;
              driveLow <= 1'b1;
              if (rxKind == RK_ADDR) isRead <= shiftReg[0];
            end
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              state    <= ST_TX;
              txShift  <= rdByte;
              driveLow <= ~rdByte[7];
            end else begin
              state    <= ST_RX;
              driveLow <= 1'b0;
              rxKind   <= (rxKind == RK_ADDR) ? RK_PTR : RK_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == CNT_LAST) begin
              state    <= ST_TXACK;
              driveLow <= 1'b0;
              bitCnt   <= '0;
            end else begin
              txShift  <= {txShift[6:0], 1'b0};
              driveLow <= ~txShift[6];
              bitCnt   <= bitCnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            masterAck <= ~sdaLvl;
          end else if (sclFall) begin
            if (masterAck) begin
              state    <= ST_TX;
              txShift  <= rdByte;
              driveLow <= ~rdByte[7];
              bitCnt   <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !driveLow);

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && !busEvent) |=> $stable(driveLow));

  // R2
  addr_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX && rxKind == RK_ADDR && bitCnt == CNT_FULL && sclFall &&
     !busEvent && !addrHit) |=> (!driveLow && state == ST_IDLE));
endmodule

// File: rtl/i2c_snap_dp.sv
`timescale 1ns/1ps
module i2c_snap_dp
  import i2c_snap_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int SNAP_REGS = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  portStrobeT                  strb,
  input  logic [7:0]                  byteIn,
  input  logic [NUM_REGS*8-1:0]       liveRegs,
  output logic [7:0]                  rdByte,
  output logic                        wrStrobe,
  output logic [$clog2(NUM_REGS)-1:0] wrAddr,
  output logic [7:0]                  wrData
);
  localparam int PTR_W  = $clog2(NUM_REGS);
  localparam int SNAP_W = SNAP_REGS * 8;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  ptrNext;
  logic [SNAP_W-1:0] shadowBits;
  logic [7:0]        viewBytes [NUM_REGS];
  logic              ptrStep;
  logic              wrapHit;
  logic              snapNow;

  assign ptrStep = strb.wrEn | strb.txLoad;
  assign wrapHit = ptrStep && (ptr == PTR_LAST);
  assign snapNow = strb.capture | wrapHit;
  assign ptrNext = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.ptrLoad) begin
      ptr <= byteIn[PTR_W-1:0];
    end else if (ptrStep) begin
      ptr <= ptrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) shadowBits <= '0;
    else if (snapNow) shadowBits <= liveRegs[SNAP_W-1:0];
  end

  // registers in the time range come from the shadow, the rest live
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
    if (g < SNAP_REGS) begin : g_snap
      assign viewBytes[g] = shadowBits[g*8 +: 8];
    end else begin : g_live
      assign viewBytes[g] = liveRegs[g*8 +: 8];
    end
  end

  assign rdByte = viewBytes[ptr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= strb.wrEn;
      if (strb.wrEn) begin
        wrAddr <= ptr;
        wrData <= byteIn;
      end
    end
  end

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R7
  snap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (shadowBits == $past(liveRegs[SNAP_W-1:0])));

  // R6 R8
  wrap_snap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ptrStep && ptr == PTR_LAST) |=>
      (ptr == '0 && shadowBits == $past(liveRegs[SNAP_W-1:0])));
endmodule

// File: rtl/i2c_snap_port.sv
`timescale 1ns/1ps
module i2c_snap_port
  import i2c_snap_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         NUM_REGS    = 16,
  parameter int         SNAP_REGS   = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaDriveLow,
  input  logic [NUM_REGS*8-1:0]       liveRegs,
  output logic                        wrStrobe,
  output logic [$clog2(NUM_REGS)-1:0] wrAddr,
  output logic [7:0]                  wrData
);
  logic       sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  portStrobeT strb;
  logic [7:0] rdByte;
  logic [7:0] rxByte;

  i2c_snap_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_snap_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rdByte(rdByte), .strb(strb), .rxByte(rxByte), .sdaDriveLow(sdaDriveLow)
  );

  i2c_snap_dp #(.NUM_REGS(NUM_REGS), .SNAP_REGS(SNAP_REGS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .byteIn(rxByte), .liveRegs(liveRegs),
    .rdByte(rdByte), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: tb/i2c_snap_port_tb_top.sv
`timescale 1ns/1ps
module i2c_snap_port_tb_top;
  localparam logic [6:0] DEV = 7'h35;
  localparam int NREG = 16;
  localparam int NSNAP = 7;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [NREG*8-1:0] liveRegs = '0;
  logic sdaDriveLow, wrStrobe;
  logic [3:0] wrAddr;
  logic [7:0] wrData;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaDriveLow;

  always #2.5 clk = ~clk;

  i2c_snap_port #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .SNAP_REGS(NSNAP)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .liveRegs(liveRegs),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData)
  );

  int total = 0;
  int bad = 0;
  int wrCount = 0;
  int driveSeen = 0;
  logic [3:0] wrA [8];
  logic [7:0] wrD [8];

  always @(negedge clk) begin
    if (wrStrobe) begin
      if (wrCount < 8) begin
        wrA[wrCount] = wrAddr;
        wrD[wrCount] = wrData;
      end
      wrCount++;
    end
    if (sdaDriveLow) driveSeen++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setLive(input int idx, input logic [7:0] val);
    liveRegs[idx*8 +: 8] = val;
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(Q);
      sclM = 1'b1; tick(2*Q);
      sclM = 1'b0; tick(Q);
    end
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    acked = ~sdaLine;
    tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      sclM = 1'b1; tick(Q);
      b[i] = sdaLine;
      tick(Q);
      sclM = 1'b0;
    end
    sdaM = ~ackIt; tick(Q);
    sclM = 1'b1; tick(2*Q);
    sclM = 1'b0; tick(Q);
    sdaM = 1'b1;
  endtask

  // start + write address + pointer byte, left open for more
  task automatic openWrite(input logic [7:0] ptrByte, input string req);
    logic a;
    busStart();
    sendByte({DEV, 1'b0}, a);
    check({req, " write address ack"}, a, 1);
    sendByte(ptrByte, a);
    check({req, " pointer byte ack"}, a, 1);
  endtask

  task automatic testReset();
    logic a;
    logic [7:0] b;
    check("R1 sda released after reset", sdaDriveLow, 0);
    check("R1 write strobe low after reset", wrStrobe, 0);
    setLive(0, 8'h5C);
    busStart();
    sendByte({DEV, 1'b1}, a);
    check("R2 matching read address acked", a, 1);
    recvByte(1'b0, b);
    check("R1 pointer starts at register 0", b, 8'h5C);
    busStop();
  endtask

  task automatic testWrite();
    logic a;
    wrCount = 0;
    openWrite(8'hF3, "R3");
    check("R3 pointer byte gives no write strobe", wrCount, 0);
    sendByte(8'hA5, a);
    check("R4 data byte acked", a, 1);
    sendByte(8'h5A, a);
    check("R4 second data byte acked", a, 1);
    busStop();
    check("R4 write strobe count", wrCount, 2);
    check("R3 pointer from low four bits", wrA[0], 4'h3);
    check("R4 first write data", wrD[0], 8'hA5);
    check("R4 pointer advanced after write", wrA[1], 4'h4);
    check("R4 second write data", wrD[1], 8'h5A);
  endtask

  task automatic testAddrMismatch();
    logic a;
    wrCount = 0;
    driveSeen = 0;
    busStart();
    sendByte({DEV ^ 7'h01, 1'b0}, a);
    check("R2 foreign address not acked", a, 0);
    sendByte(8'h02, a);
    check("R2 byte after foreign address not acked", a, 0);
    sendByte(8'h77, a);
    busStop();
    check("R2 no write after foreign address", wrCount, 0);
    check("R2 sda never driven for foreign address", driveSeen, 0);
  endtask

  task automatic testSnapRead();
    logic a;
    logic [7:0] b0, b1, b2;
    setLive(0, 8'h10); setLive(1, 8'h20); setLive(2, 8'h30);
    openWrite(8'h00, "R7");
    setLive(0, 8'h11); setLive(1, 8'h21); setLive(2, 8'h31);
    busStart();
    sendByte({DEV, 1'b1}, a);
    check("R7 read address acked after repeated start", a, 1);
    setLive(0, 8'h12); setLive(1, 8'h22); setLive(2, 8'h32);
    recvByte(1'b1, b0);
    recvByte(1'b1, b1);
    recvByte(1'b0, b2);
    busStop();
    check("R7 register 0 from repeated-start snapshot", b0, 8'h11);
    check("R7 R5 register 1 from snapshot", b1, 8'h21);
    check("R7 R5 register 2 from snapshot", b2, 8'h31);
  endtask

  task automatic testLiveRead();
    logic a;
    logic [7:0] b0, b1;
    setLive(8, 8'hC8); setLive(9, 8'hC9);
    openWrite(8'h08, "R5");
    busStart();
    sendByte({DEV, 1'b1}, a);
    setLive(9, 8'hD9);
    recvByte(1'b1, b0);
    recvByte(1'b0, b1);
    busStop();
    check("R5 register 8 read live", b0, 8'hC8);
    check("R5 register 9 read live after change", b1, 8'hD9);
  endtask

  task automatic testWrapRead();
    logic a;
    logic [7:0] b0, b1, b2;
    setLive(14, 8'h0E); setLive(15, 8'h0F); setLive(0, 8'h40);
    openWrite(8'h0E, "R6");
    busStart();
    sendByte({DEV, 1'b1}, a);
    setLive(0, 8'h41);
    recvByte(1'b1, b0);
    recvByte(1'b1, b1);
    recvByte(1'b0, b2);
    busStop();
    check("R5 register 14", b0, 8'h0E);
    check("R5 register 15", b1, 8'h0F);
    check("R6 R8 wrap to 0 refreshes snapshot", b2, 8'h41);
  endtask

  task automatic testWrapWrite();
    logic a;
    wrCount = 0;
    openWrite(8'h0F, "R6");
    sendByte(8'h61, a);
    sendByte(8'h62, a);
    busStop();
    check("R6 write count across wrap", wrCount, 2);
    check("R6 write at register 15", {wrA[0], wrD[0]}, {4'hF, 8'h61});
    check("R6 write wraps to register 0", {wrA[1], wrD[1]}, {4'h0, 8'h62});
  endtask

  task automatic testNackEnd();
    logic a;
    logic [7:0] b;
    busStart();
    sendByte({DEV, 1'b1}, a);
    recvByte(1'b0, b);
    tick(4);
    driveSeen = 0;
    sendByte(8'h00, a);
    check("R9 no ack after master nack", a, 0);
    check("R9 sda released after master nack", driveSeen, 0);
    busStop();
  endtask

  initial begin
    tick(6);
    rstN = 1'b1;
    tick(6);
    testReset();
    testWrite();
    testAddrMismatch();
    testSnapRead();
    testLiveRead();
    testWrapRead();
    testWrapWrite();
    testNackEnd();
    tick(10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule